// File: doc/BRIEF.md
# Mixed-Width Instruction Decode Packer

This block sits between an instruction fetch window and a micro-op scheduler. Each cycle it may accept a window of up to four instructions whose boundaries are already known. Every instruction carries a flag saying whether it expands to one micro-op or to two, plus an opaque tag. The block places the oldest unissued instructions on four parallel decode lanes. It then emits one registered group of at most four micro-ops together with the number of instructions that group used.

A two-micro-op instruction may only be decoded on lane 0. When that happens its second micro-op takes the output position that lane 3 would otherwise fill, so at most two single instructions can travel with it. A two-micro-op instruction that sits on a later lane ends the group in front of it. It waits, and in the next cycle it is moved to lane 0. Everything younger than it waits as well, and issue is strictly in program order. The window is held inside the block and shifted down after every issue. A new window is taken only in the cycle in which the held one drains.

Top module: `uop_pack_dec`

## Requirements
- R1: In the cycle after reset is released, `out_valid` is 0 and `in_ready` is 1.
- R2: When the leading lanes hold only single instructions (`in_dbl` bit i = 0 marks slot i as one micro-op), up to four of them issue in one group. Instruction k of the group is placed in output slot k with its `out_hi` bit at 0.
- R3: When lane 0 holds a two-micro-op instruction (`in_dbl` bit = 1), output slots 0 and 1 carry its tag, with `out_hi` bits 0 and 1 respectively. At most two following single instructions ride along, in slots 2 and 3.
- R4: A two-micro-op instruction that is not on lane 0 does not issue in that group. The group ends before it, and the next group starts with it in slot 0.
- R5: A group never holds more than one two-micro-op instruction, and `out_uops` never exceeds four.
- R6: Instructions issue in window order. The first slot of every group holds the oldest instruction not yet issued.
- R7: `out_take` equals the number of instructions in the group (1 to 4). The groups for one window together use exactly `in_cnt` instructions.
- R8: While `out_valid` is 1 and `out_ready` is 0, every output holds its value, no instruction is consumed and `in_ready` stays 0 if instructions remain held.
- R9: A window (`in_cnt` = number of valid slots from slot 0, 0 to 4) is accepted only at an edge where `in_ready` is 1. `in_ready` is 1 only when the held window drains at that edge. The first group of a newly accepted window is valid two edges after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Fetch window present |
| in_ready | output | 1 | Window accepted at this edge |
| in_cnt | input | 3 | Number of valid slots, starting at slot 0 |
| in_dbl | input | 4 | Per slot: 1 = two micro-ops |
| in_tag | input | 32 | Per slot tag, slot i at bits [8i+7:8i] |
| out_valid | output | 1 | Micro-op group present |
| out_ready | input | 1 | Scheduler takes the group |
| out_uops | output | 3 | Number of valid micro-op slots |
| out_take | output | 3 | Instructions consumed by the group |
| out_hi | output | 4 | Per slot: second micro-op of a pair |
| out_tag | output | 32 | Per slot micro-op tag |

## Verification
A window accepted at edge E reaches the lane buffer at E and gives its first registered group after edge E+1. Each later group follows one edge after the one before it while `out_ready` is high. The bench drives inputs at the falling edge, and after acceptance it waits one rising and one falling edge before each group comparison. Under backpressure it samples at every falling edge while `out_ready` is low to confirm the held group. It then expects the deferred group at the falling edge after the release edge.

// File: rtl/upd_pkg.sv
package upd_pkg;
  // Shape of the group chosen from the lane buffer in one cycle.
  typedef enum logic [1:0] {
    GRP_EMPTY,
    GRP_SINGLES,
    GRP_LEAD_DOUBLE
  } grp_kind_e;
endpackage

// File: rtl/upd_lane_sel.sv
module upd_lane_sel
  import upd_pkg::*;
#(
  parameter  int LANES = 4,
  localparam int CW    = $clog2(LANES + 1)
) (
  input  logic [CW-1:0]    cnt,
  input  logic [LANES-1:0] dbl,
  output grp_kind_e        kind,
  output logic [CW-1:0]    take,
  output logic [CW-1:0]    uops
);
  localparam int RIDE_MAX = LANES - 2;  // singles that fit beside a lane-0 pair

  logic [CW-1:0] run;  // single instructions directly behind lane 0
  logic          stop;

  always_comb begin
    run  = '0;
    stop = 1'b0;
    for (int i = 1; i < LANES; i++) begin
      if (!stop && (CW'(i) < cnt) && !dbl[i]) run = run + 1'b1;
      else stop = 1'b1;
    end
    if (cnt == '0) begin
      kind = GRP_EMPTY;
      take = '0;
      uops = '0;
    end else if (dbl[0]) begin
      kind = GRP_LEAD_DOUBLE;
      take = CW'(1) + ((run > CW'(RIDE_MAX)) ? CW'(RIDE_MAX) : run);
      uops = take + CW'(1);
    end else begin
      kind = GRP_SINGLES;
      take = run + CW'(1);
      uops = take;
    end
  end
endmodule

// File: rtl/upd_slot_mux.sv
module upd_slot_mux
  import upd_pkg::*;
#(
  parameter int LANES = 4,
  parameter int TW    = 8
) (
  input  grp_kind_e           kind,
  input  logic [LANES*TW-1:0] tag,
  output logic [LANES*TW-1:0] slot_tag,
  output logic [LANES-1:0]    slot_hi
);
  logic pair;
  assign pair = (kind == GRP_LEAD_DOUBLE);

  for (genvar j = 0; j < LANES; j++) begin : g_slot
    if (j == 0) begin : g_lead
      assign slot_tag[0 +: TW] = tag[0 +: TW];
      assign slot_hi[0]        = 1'b0;
    end else if (j == 1) begin : g_pair_half
      assign slot_tag[TW +: TW] = pair ? tag[0 +: TW] : tag[TW +: TW];
      assign slot_hi[1]         = pair;
    end else begin : g_rider
      // A lane-0 pair pushes every following lane one output slot up.
      assign slot_tag[j*TW +: TW] = pair ? tag[(j-1)*TW +: TW] : tag[j*TW +: TW];
      assign slot_hi[j]           = 1'b0;
    end
  end
endmodule

// File: rtl/upd_window.sv
module upd_window #(
  parameter  int LANES = 4,
  parameter  int TW    = 8,
  localparam int CW    = $clog2(LANES + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                adv,
  input  logic [CW-1:0]       take,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [CW-1:0]       in_cnt,
  input  logic [LANES-1:0]    in_dbl,
  input  logic [LANES*TW-1:0] in_tag,
  output logic [CW-1:0]       cnt_q,
  output logic [LANES-1:0]    dbl_q,
  output logic [LANES*TW-1:0] tag_q
);
  logic [CW-1:0]       eff;
  logic [CW-1:0]       left;
  logic [LANES-1:0]    nxt_dbl;
  logic [LANES*TW-1:0] nxt_tag;

  assign eff      = adv ? take : '0;
  assign left     = cnt_q - eff;
  assign in_ready = adv && (left == '0);

  // Realign: the oldest instruction still held moves to lane 0.
  always_comb begin
    nxt_dbl = '0;
    nxt_tag = '0;
    for (int i = 0; i < LANES; i++) begin
      if (i + int'(eff) < LANES) begin
        nxt_dbl[i]          = dbl_q[i + int'(eff)];
        nxt_tag[i*TW +: TW] = tag_q[(i + int'(eff))*TW +: TW];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      dbl_q <= '0;
      tag_q <= '0;
    end else if (in_valid && in_ready) begin
      cnt_q <= in_cnt;
      dbl_q <= in_dbl;
      tag_q <= in_tag;
    end else if (adv) begin
      cnt_q <= left;
      dbl_q <= nxt_dbl;
      tag_q <= nxt_tag;
    end
  end

  // R8: a stalled output freezes the held instructions.
  p_hold_window_r8: assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(cnt_q) && $stable(tag_q) && $stable(dbl_q));

  // R9: nothing new is taken while instructions remain held after this edge.
  p_drain_first_r9: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |-> (cnt_q == '0) || (adv && take == cnt_q));
endmodule

// File: rtl/upd_out_reg.sv
module upd_out_reg #(
  parameter  int LANES = 4,
  parameter  int TW    = 8,
  localparam int CW    = $clog2(LANES + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                out_ready,
  output logic                adv,
  input  logic [CW-1:0]       nxt_take,
  input  logic [CW-1:0]       nxt_uops,
  input  logic [LANES-1:0]    nxt_hi,
  input  logic [LANES*TW-1:0] nxt_tag,
  output logic                out_valid,
  output logic [CW-1:0]       out_take,
  output logic [CW-1:0]       out_uops,
  output logic [LANES-1:0]    out_hi,
  output logic [LANES*TW-1:0] out_tag
);
  assign adv = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_take  <= '0;
      out_uops  <= '0;
      out_hi    <= '0;
      out_tag   <= '0;
    end else if (adv) begin
      out_valid <= (nxt_take != '0);
      out_take  <= nxt_take;
      out_uops  <= nxt_uops;
      out_hi    <= nxt_hi;
      out_tag   <= nxt_tag;
    end
  end

  p_hold_out_r8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> out_valid && $stable(out_tag)
      && $stable(out_hi) && $stable(out_take) && $stable(out_uops));

  p_one_pair_r5: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ($countones(out_hi) <= 1) && (out_uops <= CW'(LANES)));

  p_pair_slots_r3: assert property (@(posedge clk) disable iff (rst)
    (out_valid && (out_hi != '0)) |-> out_hi[1] && (out_uops == out_take + CW'(1)));

  p_take_range_r7: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_take != '0) && (out_take <= CW'(LANES)));
endmodule

// File: rtl/uop_pack_dec.sv
module uop_pack_dec
  import upd_pkg::*;
#(
  parameter  int LANES = 4,
  parameter  int TAG_W = 8,
  localparam int CW    = $clog2(LANES + 1)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [CW-1:0]          in_cnt,
  input  logic [LANES-1:0]       in_dbl,
  input  logic [LANES*TAG_W-1:0] in_tag,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [CW-1:0]          out_uops,
  output logic [CW-1:0]          out_take,
  output logic [LANES-1:0]       out_hi,
  output logic [LANES*TAG_W-1:0] out_tag
);
  logic                   adv;
  logic [CW-1:0]          cnt_q;
  logic [LANES-1:0]       dbl_q;
  logic [LANES*TAG_W-1:0] tag_q;
  grp_kind_e              kind;
  logic [CW-1:0]          take;
  logic [CW-1:0]          uops;
  logic [LANES*TAG_W-1:0] slot_tag;
  logic [LANES-1:0]       slot_hi;

  upd_window #(.LANES(LANES), .TW(TAG_W)) win_i (
    .clk(clk), .rst(rst), .adv(adv), .take(take),
    .in_valid(in_valid), .in_ready(in_ready), .in_cnt(in_cnt),
    .in_dbl(in_dbl), .in_tag(in_tag),
    .cnt_q(cnt_q), .dbl_q(dbl_q), .tag_q(tag_q)
  );

  upd_lane_sel #(.LANES(LANES)) sel_i (
    .cnt(cnt_q), .dbl(dbl_q), .kind(kind), .take(take), .uops(uops)
  );

  upd_slot_mux #(.LANES(LANES), .TW(TAG_W)) mux_i (
    .kind(kind), .tag(tag_q), .slot_tag(slot_tag), .slot_hi(slot_hi)
  );

  upd_out_reg #(.LANES(LANES), .TW(TAG_W)) oreg_i (
    .clk(clk), .rst(rst), .out_ready(out_ready), .adv(adv),
    .nxt_take(take), .nxt_uops(uops), .nxt_hi(slot_hi), .nxt_tag(slot_tag),
    .out_valid(out_valid), .out_take(out_take), .out_uops(out_uops),
    .out_hi(out_hi), .out_tag(out_tag)
  );

  // R9: a non-empty window yields a valid group two edges after acceptance.
  p_first_group_r9: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && in_cnt != '0) |=> ##1 out_valid);
endmodule

// File: tb/uop_pack_dec_tb_top.sv
`timescale 1ns/1ps
module uop_pack_dec_tb_top;
  localparam int LANES = 4;
  localparam int TW    = 8;
  localparam int CW    = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic                in_valid = 1'b0;
  logic                in_ready;
  logic [CW-1:0]       in_cnt   = '0;
  logic [LANES-1:0]    in_dbl   = '0;
  logic [LANES*TW-1:0] in_tag   = '0;
  logic                out_valid;
  logic                out_ready = 1'b1;
  logic [CW-1:0]       out_uops;
  logic [CW-1:0]       out_take;
  logic [LANES-1:0]    out_hi;
  logic [LANES*TW-1:0] out_tag;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  uop_pack_dec #(.LANES(LANES), .TAG_W(TW)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_cnt(in_cnt), .in_dbl(in_dbl), .in_tag(in_tag),
    .out_valid(out_valid), .out_ready(out_ready), .out_uops(out_uops),
    .out_take(out_take), .out_hi(out_hi), .out_tag(out_tag)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [TW-1:0] tg(input int c, input int d, input int s);
    return TW'((((c - 1) & 3) << 6) | ((d & 15) << 2) | (s & 3));
  endfunction

  // Wait for the next group and compare every field of it.
  task automatic expect_group(input string req, input int n, input int u,
                              input logic [LANES*TW-1:0] et, input logic [LANES-1:0] eh);
    @(posedge clk);
    @(negedge clk);
    chk("R7 valid", out_valid, 1);
    chk("R7 take", out_take, n);
    chk("R5 uops", out_uops, u);
    for (int j = 0; j < u; j++) begin
      chk((j == 0) ? "R6 oldest first" : req, out_tag[j*TW +: TW], et[j*TW +: TW]);
      chk(req, out_hi[j], eh[j]);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [LANES*TW-1:0] et;
    logic [LANES-1:0]    eh;
    logic [3:0]          dm;
    int pos, n, u, total;
    string rq;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 out_valid", out_valid, 0);
    chk("R1 in_ready", in_ready, 1);

    // Sweep every window length and every single/pair mix.
    for (int c = 1; c <= LANES; c++) begin
      for (int d = 0; d < 16; d++) begin
        dm = 4'(d);
        chk("R9 ready when drained", in_ready, 1);
        in_valid = 1'b1;
        in_cnt   = CW'(c);
        in_dbl   = dm;
        for (int s = 0; s < LANES; s++) in_tag[s*TW +: TW] = tg(c, d, s);
        @(posedge clk);
        #1 in_valid = 1'b0;
        pos = 0;
        total = 0;
        while (pos < c) begin
          et = '0;
          eh = '0;
          if (dm[pos]) begin
            et[0 +: TW]  = tg(c, d, pos);
            et[TW +: TW] = tg(c, d, pos);
            eh[1] = 1'b1;
            n = 1;
            while (pos + n < c && !dm[pos + n] && n < 3) begin
              et[(n + 1)*TW +: TW] = tg(c, d, pos + n);
              n++;
            end
            u  = n + 1;
            rq = (pos == 0) ? "R3 lead pair" : "R4 deferred pair";
          end else begin
            n = 0;
            while (pos + n < c && !dm[pos + n] && n < 4) begin
              et[n*TW +: TW] = tg(c, d, pos + n);
              n++;
            end
            u  = n;
            rq = "R2 singles";
          end
          expect_group(rq, n, u, et, eh);
          pos   += n;
          total += n;
        end
        chk("R7 window total", total, c);
      end
    end

    // Backpressure: single, then a pair on lane 1 with two singles behind it.
    in_valid = 1'b1;
    in_cnt   = 3'd4;
    in_dbl   = 4'b0010;
    for (int s = 0; s < LANES; s++) in_tag[s*TW +: TW] = TW'(8'hA0 + s);
    @(posedge clk);
    #1 begin
      in_valid  = 1'b0;
      out_ready = 1'b0;
    end
    @(posedge clk);
    @(negedge clk);
    chk("R4 group ends before pair", out_take, 1);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R8 held valid", out_valid, 1);
      chk("R8 held take", out_take, 1);
      chk("R8 held tag", out_tag[0 +: TW], 8'hA0);
      chk("R8 no accept", in_ready, 0);
    end
    out_ready = 1'b1;
    et = {8'hA3, 8'hA2, 8'hA1, 8'hA1};
    eh = 4'b0010;
    expect_group("R4 pair moved to lane 0", 3, 4, et, eh);
    @(posedge clk);
    @(negedge clk);
    chk("R7 drained", out_valid, 0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule